// File: doc/BRIEF.md
# Signed Right Shift Execution Unit

This unit performs a sign-preserving right shift on an operand of 8, 16, 32 or 64 bits. Each vacated upper bit takes a copy of the operand's sign bit, so the result is the operand divided by a power of two and rounded toward negative infinity. The shift amount comes either from an immediate field or from a count register value, and a select input chooses between them. The raw amount is reduced to the range that the operand size allows.

Each accepted operation is marked by a one-cycle valid strobe. The result and a five-flag register are updated on that clock edge. The flags are carry, overflow, sign, zero and parity. A zero effective count passes the operand through and leaves all flags unchanged. The unit is meant to sit in an execution pipeline after decode, and the caller supplies the operand already read.

Top module: `asr_unit`

## Requirements
- R1: Each shifted position copies the operand's sign bit into the vacated top bit of the selected size, so rounding is toward negative infinity (32-bit 0xFFFFFFF5 shifted by 2 gives 0xFFFFFFFD).
- R2: For sizes 8, 16 and 32 (size_i = 0, 1, 2), the effective count is the low 5 bits of the raw count.
- R3: For size 64 (size_i = 3), the effective count is the low 6 bits of the raw count.
- R4: After a nonzero effective count n, cf_o equals operand bit n-1. All other shifted-out bits are discarded.
- R5: An effective count of exactly 1 clears of_o to 0.
- R6: An effective count greater than 1 leaves of_o at its previous value.
- R7: An effective count of 0 leaves all five flags unchanged and gives a result equal to the size-truncated operand.
- R8: An effective count at or above the operand width gives a result made only of copies of the sign bit, and cf_o equals the sign bit.
- R9: After a nonzero count, sf_o is the top bit of the size-truncated result, zf_o is set when that result is zero, and pf_o is set when result bits 7:0 contain an even number of ones.
- R10: result_o and the flags load only on a clock edge with valid_i high, and hold their values otherwise.
- R11: A synchronous active-high rst clears result_o and all flags.
- R12: Operand bits above the selected size are ignored, and result_o bits above the selected size are zero.
- R13: cnt_sel_i = 1 takes the raw count from reg_cnt_i, and cnt_sel_i = 0 takes it from imm_cnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| op_i | input | 64 | Operand |
| cnt_sel_i | input | 1 | Count source: 1 register, 0 immediate |
| imm_cnt_i | input | 8 | Immediate raw count |
| reg_cnt_i | input | 8 | Register raw count |
| result_o | output | 64 | Registered shift result |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (even ones in low byte) |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and 8-bit raw counts. With these values all four operand sizes can be exercised. The raw count can also go well past the 5- and 6-bit limits, so the bench can check that the high count bits are dropped. The effective count can exceed the 8- and 16-bit widths, which exercises the all-sign-bits result and the carry rule for that case.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } opsize_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
  } flags_t;
endpackage

// File: rtl/asr_count_mask.sv
module asr_count_mask
  import asr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SHAMT_W = 6
) (
  input  opsize_e            size_i,
  input  logic               cnt_sel_i,
  input  logic [CNT_W-1:0]   imm_cnt_i,
  input  logic [CNT_W-1:0]   reg_cnt_i,
  output logic [SHAMT_W-1:0] eff_o
);
  logic [CNT_W-1:0] raw;

  always_comb begin
    raw = cnt_sel_i ? reg_cnt_i : imm_cnt_i;
    if (size_i == SZ_DBL)
      eff_o = raw[SHAMT_W-1:0];
    else
      eff_o = {1'b0, raw[SHAMT_W-2:0]};
  end
endmodule

// File: rtl/asr_sign_ext.sv
module asr_sign_ext
  import asr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  opsize_e           size_i,
  input  logic [DATA_W-1:0] op_i,
  output logic [DATA_W-1:0] ext_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              sign_o
);
  localparam int LANES = 4;

  logic [DATA_W-1:0] ext_arr  [LANES];
  logic [DATA_W-1:0] mask_arr [LANES];
  logic              sgn_arr  [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (LANES - 1 - g);
    assign mask_arr[g] = {DATA_W{1'b1}} >> (DATA_W - LW);
    assign sgn_arr[g]  = op_i[LW-1];
    assign ext_arr[g]  = (op_i & mask_arr[g]) |
                         (sgn_arr[g] ? ~mask_arr[g] : {DATA_W{1'b0}});
  end

  always_comb begin
    ext_o  = ext_arr[size_i];
    mask_o = mask_arr[size_i];
    sign_o = sgn_arr[size_i];
  end
endmodule

// File: rtl/asr_core.sv
module asr_core #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 6
) (
  input  logic [DATA_W-1:0]  ext_i,
  input  logic [DATA_W-1:0]  mask_i,
  input  logic [SHAMT_W-1:0] eff_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               cf_o,
  output logic               sf_o,
  output logic               zf_o,
  output logic               pf_o
);
  logic [DATA_W-1:0]  shifted;
  logic [DATA_W-1:0]  top_bit;
  logic [SHAMT_W-1:0] last_idx;

  always_comb begin
    shifted  = $signed(ext_i) >>> eff_i;
    res_o    = shifted & mask_i;
    last_idx = eff_i - 1'b1;
    cf_o     = (eff_i == '0) ? 1'b0 : ext_i[last_idx];
    top_bit  = mask_i ^ (mask_i >> 1);
    sf_o     = |(res_o & top_bit);
    zf_o     = (res_o == '0);
    pf_o     = ~^res_o[7:0];
  end
endmodule

// File: rtl/asr_unit.sv
module asr_unit
  import asr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic              cnt_sel_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [CNT_W-1:0]  reg_cnt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              pf_o
);
  localparam int SHAMT_W = $clog2(DATA_W);

  opsize_e            size;
  logic [SHAMT_W-1:0] eff;
  logic [DATA_W-1:0]  ext, lane_mask, shres;
  logic               lane_sign;
  logic               n_cf, n_sf, n_zf, n_pf;
  flags_t             flags_q;
  logic [DATA_W-1:0]  res_q;

  assign size = opsize_e'(size_i);

  asr_count_mask #(.CNT_W(CNT_W), .SHAMT_W(SHAMT_W)) u_cnt (
    .size_i(size), .cnt_sel_i(cnt_sel_i), .imm_cnt_i(imm_cnt_i),
    .reg_cnt_i(reg_cnt_i), .eff_o(eff)
  );

  asr_sign_ext #(.DATA_W(DATA_W)) u_ext (
    .size_i(size), .op_i(op_i), .ext_o(ext), .mask_o(lane_mask),
    .sign_o(lane_sign)
  );

  asr_core #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_core (
    .ext_i(ext), .mask_i(lane_mask), .eff_i(eff), .res_o(shres),
    .cf_o(n_cf), .sf_o(n_sf), .zf_o(n_zf), .pf_o(n_pf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (valid_i) begin
      res_q <= shres;
      if (eff != '0) begin
        flags_q.cf <= n_cf;
        flags_q.of <= (eff == SHAMT_W'(1)) ? 1'b0 : flags_q.of;
        flags_q.sf <= n_sf;
        flags_q.zf <= n_zf;
        flags_q.pf <= n_pf;
      end
    end
  end

  assign result_o = res_q;
  assign cf_o     = flags_q.cf;
  assign of_o     = flags_q.of;
  assign sf_o     = flags_q.sf;
  assign zf_o     = flags_q.zf;
  assign pf_o     = flags_q.pf;

  // R7
  zero_cnt_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && eff == '0) |=> (flags_q == $past(flags_q)));

  // R5
  one_cnt_of_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && eff == SHAMT_W'(1)) |=> !of_o);

  // R12
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ((result_o & ~$past(lane_mask)) == '0));

  // R1
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && eff != '0) |=> (sf_o == $past(lane_sign)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(result_o) && $stable(flags_q)));
endmodule

// File: tb/asr_unit_bench.sv
module asr_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  size_i;
  logic [63:0] op_i;
  logic        cnt_sel_i;
  logic [7:0]  imm_cnt_i, reg_cnt_i;
  logic [63:0] result_o;
  logic        cf_o, of_o, sf_o, zf_o, pf_o;

  int tests = 0;
  int fails = 0;

  logic [63:0] e_res;
  logic [4:0]  e_flg;

  asr_unit u_asr_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .size_i(size_i), .op_i(op_i),
    .cnt_sel_i(cnt_sel_i), .imm_cnt_i(imm_cnt_i), .reg_cnt_i(reg_cnt_i),
    .result_o(result_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o),
    .zf_o(zf_o), .pf_o(pf_o)
  );

  always #5 clk = ~clk;

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk64({req, " result"}, result_o, e_res);
    chk64({req, " flags cf,of,sf,zf,pf"},
          {59'd0, cf_o, of_o, sf_o, zf_o, pf_o}, {59'd0, e_flg});
  endtask

  // Bench model: bit-by-bit shift, one position per step
  task automatic model(logic [1:0] sz, logic [63:0] op, logic sel,
                       logic [7:0] imm, logic [7:0] rg);
    int          w   = 8 << sz;
    logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] v   = op & msk;
    logic [7:0]  raw = sel ? rg : imm;
    int          n   = (sz == 2'd3) ? int'(raw & 8'd63) : int'(raw & 8'd31);
    logic        s   = v[w-1];
    logic        c   = 1'b0;
    for (int i = 0; i < n; i++) begin
      c = v[0];
      v = v >> 1;
      v[w-1] = s;
    end
    e_res = v;
    if (n != 0) begin
      e_flg[4] = c;
      if (n == 1) e_flg[3] = 1'b0;
      e_flg[2] = v[w-1];
      e_flg[1] = (v == 64'd0);
      e_flg[0] = ~^v[7:0];
    end
  endtask

  task automatic run_op(logic [1:0] sz, logic [63:0] op, logic sel,
                        logic [7:0] imm, logic [7:0] rg, string req);
    @(negedge clk);
    size_i = sz; op_i = op; cnt_sel_i = sel; imm_cnt_i = imm; reg_cnt_i = rg;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    model(sz, op, sel, imm, rg);
    chk_all(req);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    e_res = '0; e_flg = '0;
    chk_all("R11 reset");
  endtask

  task automatic t_round();
    run_op(2'd2, 64'h0000_0000_FFFF_FFF5, 1'b0, 8'd2, 8'd0, "R1 round");
    chk64("R1 literal", result_o, 64'h0000_0000_FFFF_FFFD);
    run_op(2'd1, 64'h0000_0000_0000_8001, 1'b0, 8'd3, 8'd0, "R1 half neg");
    run_op(2'd2, 64'h0000_0000_7000_0000, 1'b0, 8'd4, 8'd0, "R1 positive");
  endtask

  task automatic t_mask32();
    run_op(2'd2, 64'h0000_0000_8000_00F0, 1'b0, 8'd33, 8'd0, "R2 count33");
    chk64("R2 as shift1", result_o, 64'h0000_0000_C000_0078);
    run_op(2'd0, 64'h0000_0000_0000_0040, 1'b0, 8'hE2, 8'd0, "R2 byte mask");
  endtask

  task automatic t_mask64();
    run_op(2'd3, 64'h8000_0000_0000_0003, 1'b0, 8'd65, 8'd0, "R3 count65");
    chk64("R3 as shift1", result_o, 64'hC000_0000_0000_0001);
    run_op(2'd3, 64'h8000_0000_0000_0000, 1'b0, 8'd63, 8'd0, "R3 count63");
  endtask

  task automatic t_carry();
    run_op(2'd2, 64'h0000_0000_0000_0004, 1'b0, 8'd3, 8'd0, "R4 cf one");
    chk64("R4 cf", {63'd0, cf_o}, 64'd1);
    run_op(2'd2, 64'h0000_0000_0000_000B, 1'b0, 8'd3, 8'd0, "R4 cf zero");
    chk64("R4 cf", {63'd0, cf_o}, 64'd0);
  endtask

  task automatic t_of();
    run_op(2'd2, 64'h0000_0000_0000_0003, 1'b0, 8'd1, 8'd0, "R5 of clear");
    run_op(2'd2, 64'h0000_0000_8000_0000, 1'b0, 8'd5, 8'd0, "R6 of hold");
    chk64("R6 of", {63'd0, of_o}, 64'd0);
  endtask

  task automatic t_zero();
    run_op(2'd3, 64'hFFFF_0000_0000_0001, 1'b0, 8'd9, 8'd0, "R7 setup");
    run_op(2'd1, 64'hABCD_0000_0000_1234, 1'b0, 8'd32, 8'd0, "R7 zero count");
    chk64("R7 passthrough", result_o, 64'h0000_0000_0000_1234);
    run_op(2'd3, 64'h0000_0000_0000_0000, 1'b0, 8'd64, 8'd0, "R7 zero dbl");
  endtask

  task automatic t_wide();
    run_op(2'd0, 64'h0000_0000_0000_0085, 1'b0, 8'd20, 8'd0, "R8 byte neg");
    chk64("R8 all sign", result_o, 64'h0000_0000_0000_00FF);
    run_op(2'd1, 64'h0000_0000_0000_7FFF, 1'b0, 8'd16, 8'd0, "R8 half pos");
    chk64("R8 cf", {63'd0, cf_o}, 64'd0);
    run_op(2'd0, 64'h0000_0000_0000_0080, 1'b0, 8'd8, 8'd0, "R8 eq width");
  endtask

  task automatic t_flags();
    run_op(2'd2, 64'h0000_0000_0000_0001, 1'b0, 8'd1, 8'd0, "R9 zero res");
    run_op(2'd2, 64'h0000_0000_0000_0E00, 1'b0, 8'd4, 8'd0, "R9 parity odd");
    run_op(2'd2, 64'h0000_0000_0000_0C00, 1'b0, 8'd4, 8'd0, "R9 parity even");
  endtask

  task automatic t_hold();
    @(negedge clk);
    size_i = 2'd0; op_i = 64'hFF; imm_cnt_i = 8'd1; cnt_sel_i = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_all("R10 idle hold");
  endtask

  task automatic t_upper();
    run_op(2'd0, 64'hFFFF_FFFF_FFFF_FF12, 1'b0, 8'd1, 8'd0, "R12 upper");
    chk64("R12 literal", result_o, 64'h0000_0000_0000_0009);
  endtask

  task automatic t_src();
    run_op(2'd2, 64'h0000_0000_0000_0100, 1'b1, 8'd1, 8'd4, "R13 reg src");
    chk64("R13 reg", result_o, 64'h0000_0000_0000_0010);
    run_op(2'd2, 64'h0000_0000_0000_0100, 1'b0, 8'd1, 8'd4, "R13 imm src");
    chk64("R13 imm", result_o, 64'h0000_0000_0000_0080);
  endtask

  initial begin
    rst = 1'b1; valid_i = 1'b0; size_i = '0; op_i = '0;
    cnt_sel_i = 1'b0; imm_cnt_i = '0; reg_cnt_i = '0;
    e_res = '0; e_flg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R11 initial");
    t_round();
    t_mask32();
    t_mask64();
    t_carry();
    t_of();
    t_zero();
    t_wide();
    t_flags();
    t_hold();
    t_upper();
    t_src();
    run_op(2'd2, 64'h0000_0000_8000_0001, 1'b0, 8'd2, 8'd0, "R11 pre");
    t_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule